// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of a serial peripheral master from the module clock. A single configuration word carries two divider settings and a law-select bit. In the linear law an 8-bit ratio sets the serial period to twice (ratio + 1) module clocks. In the power-of-two law a 4-bit exponent sets the serial period to 2 raised to that exponent. The block emits a one-cycle tick on every serial clock edge and a matching serial clock level. A neighbouring shifter uses the tick to move data.

The divider runs only while the transfer-active input is high. A two-state controller governs it. In state IDLE the half-period counter is held at zero and the level is held low. The transition IDLE to RUN is taken on the first cycle with the transfer active. On that same edge the half-period chosen by the configuration word is captured. In state RUN the counter climbs to the captured half-period, then wraps and raises a tick, and the controller stays in RUN. The transition RUN to IDLE is taken on any cycle where the transfer is no longer active. Because the word is captured only on entry to RUN, a new setting first applies to the following burst.

Top module: `sclk_divider`

## Requirements
- R1: The configuration word `div_word` has its linear ratio in bits [7:0], its exponent in bits [11:8] and the law select in bit 12. Bit 12 = 1 picks the linear law and bit 12 = 0 picks the power-of-two law. The field that the chosen law does not use has no effect.
- R2: In the linear law, ticks are spaced (ratio + 1) module clocks apart, so the serial period is 2 x (ratio + 1) module clocks.
- R3: In the power-of-two law with an exponent e of 1 or more, ticks are spaced 2^(e-1) module clocks apart, so the serial period is 2^e module clocks.
- R4: In the power-of-two law, an exponent of 0 behaves exactly like an exponent of 1, which is division by 2.
- R5: No tick is issued, and `sclk_level` stays low, while `xfer_active` is low. A tick is only possible in a cycle whose previous cycle had `xfer_active` high.
- R6: The counter restarts at every burst. If `xfer_active` is first high in cycle 0 and H is the half-period, the first tick is asserted in cycle H.
- R7: `sclk_level` is low at the start of each burst. It inverts in the cycle after each tick, which gives a 50% duty cycle.
- R8: `div_word` is sampled only on the first active cycle of a burst. Changes made during the burst take effect at the next burst.
- R9: The fastest setting, linear ratio 0, ticks in every active cycle from cycle 1 on, so the serial clock runs at half the module clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | High while a transfer is in progress |
| div_word | input | 13 | Configuration word: ratio, exponent and law select |
| sclk_tick | output | 1 | One-cycle pulse at every serial clock edge |
| sclk_level | output | 1 | Serial clock level, idle low |

## Verification
The assertions assume that `xfer_active` is a clean level driven on clock edges. They also assume that `div_word` holds a real value on the first active cycle of a burst, because the checker captures the word at that edge itself. The checker then measures the spacing between ticks against the half-period it derives from that capture. The bench keeps to these assumptions by changing inputs only at the falling edge of the clock. It also always sets the word before it raises the transfer-active input. The only exception is the one deliberate change made during a burst, which is also made at a falling edge.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

    typedef enum logic [0:0] {
        SD_IDLE = 1'b0,
        SD_RUN  = 1'b1
    } sd_state_e;

endpackage

// File: rtl/sclk_half_decode.sv
module sclk_half_decode #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 15,
    localparam int CFG_W = LIN_W + EXP_W + 1
) (
    input  logic [CFG_W-1:0] cfg_word,
    output logic [CNT_W-1:0] half_cycles
);

    logic [LIN_W-1:0] ratio_f;
    logic [EXP_W-1:0] expo_f;
    logic             lin_sel;

    assign ratio_f = cfg_word[LIN_W-1:0];
    assign expo_f  = cfg_word[LIN_W +: EXP_W];
    assign lin_sel = cfg_word[CFG_W-1];

    always_comb begin
        if (lin_sel) begin
            half_cycles = CNT_W'(ratio_f) + CNT_W'(1);
        end else if (expo_f == '0) begin
            half_cycles = CNT_W'(1);
        end else begin
            half_cycles = CNT_W'(1) << (expo_f - EXP_W'(1));
        end
    end

endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer
    import sclkdiv_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_in,
    output logic             edge_tick
);

    sd_state_e        state_q, state_d;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_last;

    assign cnt_last = half_q - CNT_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_IDLE: if (run)  state_d = SD_RUN;
            SD_RUN:  if (!run) state_d = SD_IDLE;
            default: state_d = SD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= CNT_W'(1);
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                SD_IDLE: begin
                    cnt_q <= '0;
                    if (run) half_q <= half_in;
                end
                SD_RUN: begin
                    if (!run || cnt_q == cnt_last) cnt_q <= '0;
                    else                           cnt_q <= cnt_q + CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        edge_tick = 1'b0;
        unique case (state_q)
            SD_IDLE: edge_tick = 1'b0;
            SD_RUN:  edge_tick = (cnt_q == cnt_last);
            default: edge_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/sclk_level_gen.sv
module sclk_level_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic edge_tick,
    output logic level
);

    always_ff @(posedge clk) begin
        if (!rst_n)         level <= 1'b0;
        else if (!run)      level <= 1'b0;
        else if (edge_tick) level <= ~level;
    end

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CFG_W = LIN_W + EXP_W + 1,
    localparam int POW_W = (1 << EXP_W) - 1,
    localparam int CNT_W = (LIN_W + 1 > POW_W) ? LIN_W + 1 : POW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic [CFG_W-1:0] div_word,
    output logic             sclk_tick,
    output logic             sclk_level
);

    logic [CNT_W-1:0] half_cycles;

    sclk_half_decode #(
        .LIN_W(LIN_W),
        .EXP_W(EXP_W),
        .CNT_W(CNT_W)
    ) u_decode (
        .cfg_word   (div_word),
        .half_cycles(half_cycles)
    );

    sclk_half_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (xfer_active),
        .half_in  (half_cycles),
        .edge_tick(sclk_tick)
    );

    sclk_level_gen u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (xfer_active),
        .edge_tick(sclk_tick),
        .level    (sclk_level)
    );

endmodule

// File: rtl/sclk_divider_checker.sv
module sclk_divider_checker #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CFG_W = LIN_W + EXP_W + 1,
    localparam int POW_W = (1 << EXP_W) - 1,
    localparam int CNT_W = (LIN_W + 1 > POW_W) ? LIN_W + 1 : POW_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_active,
    input logic [CFG_W-1:0] div_word,
    input logic             sclk_tick,
    input logic             sclk_level
);

    logic             ck_prev;
    logic [CNT_W:0]   ck_half;
    logic [CNT_W:0]   ck_gap;
    logic [LIN_W-1:0] w_ratio;
    logic [EXP_W-1:0] w_exp;
    int unsigned      w_shift;

    assign w_ratio = div_word[LIN_W-1:0];
    assign w_exp   = div_word[LIN_W +: EXP_W];
    assign w_shift = (w_exp == '0) ? 0 : int'(w_exp) - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_prev <= 1'b0;
            ck_half <= '0;
            ck_gap  <= '0;
        end else begin
            ck_prev <= xfer_active;
            if (!xfer_active) begin
                ck_gap <= '0;
            end else if (!ck_prev) begin
                ck_gap  <= (CNT_W+1)'(1);
                ck_half <= div_word[CFG_W-1] ? (CNT_W+1)'(w_ratio) + (CNT_W+1)'(1)
                                             : (CNT_W+1)'(1) << w_shift;
            end else if (sclk_tick) begin
                ck_gap <= (CNT_W+1)'(1);
            end else begin
                ck_gap <= ck_gap + (CNT_W+1)'(1);
            end
        end
    end

    // R2 R3 R4 R6 R8: tick spacing equals the half-period captured at burst start
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_tick && ck_prev) |-> (ck_gap == ck_half));

    assert_tick_needs_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tick |-> $past(xfer_active));

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !sclk_level);

    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !sclk_tick) |=> $stable(sclk_level));

    assert_level_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && sclk_tick) |=> (sclk_level != $past(sclk_level)));

    assert_start_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !ck_prev) |-> !sclk_tick);

endmodule

bind sclk_divider sclk_divider_checker #(
    .LIN_W(LIN_W),
    .EXP_W(EXP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_active(xfer_active),
    .div_word   (div_word),
    .sclk_tick  (sclk_tick),
    .sclk_level (sclk_level)
);

// File: tb/tb_sclk_divider.sv
module tb_sclk_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_active = 1'b0;
    logic [12:0] div_word = '0;
    logic        sclk_tick;
    logic        sclk_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sclk_divider dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_active(xfer_active),
        .div_word   (div_word),
        .sclk_tick  (sclk_tick),
        .sclk_level (sclk_level)
    );

    function automatic int exp_half(input logic [12:0] w);
        if (w[12]) return int'(w[7:0]) + 1;
        if (w[11:8] == 4'd0) return 1;
        return 1 << (int'(w[11:8]) - 1);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic idle_gap(input int n);
        xfer_active = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R5 idle tick", int'(sclk_tick), 0);
            check("R5 idle level", int'(sclk_level), 0);
        end
    endtask

    // Runs one burst. The word is switched to new_word at cycle chg_at (0 = never).
    task automatic burst(input string req, input logic [12:0] w, input int h,
                         input int chg_at, input logic [12:0] new_word);
        int t1 = -1;
        int t2 = -1;
        int lv_a = -1;
        int lv_b = -1;
        div_word    = w;
        xfer_active = 1'b1;
        check({req, " R6 no tick at start"}, int'(sclk_tick), 0);
        for (int c = 1; c <= 2 * h + 1; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == chg_at) div_word = new_word;
            if (sclk_tick) begin
                if (t1 < 0) t1 = c;
                else if (t2 < 0) t2 = c;
            end
            if (c == h)     lv_a = int'(sclk_level);
            if (c == h + 1) lv_b = int'(sclk_level);
        end
        check({req, " R6 first tick"}, t1, h);
        check({req, " second tick"}, t2, 2 * h);
        check({req, " R7 level before edge"}, lv_a, 0);
        check({req, " R7 level after edge"}, lv_b, 1);
        idle_gap(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R5 reset tick", int'(sclk_tick), 0);
        check("R5 reset level", int'(sclk_level), 0);
        rst_n = 1'b1;
        idle_gap(4);

        // R1 R2: linear sweep, with junk placed in the exponent field
        for (int v = 0; v < 32; v++) begin
            logic [12:0] w;
            w = {1'b1, 4'(v), 8'(v)};
            burst("R2 linear", w, exp_half(w), 0, w);
        end
        burst("R1 linear ignores exponent", {1'b1, 4'hF, 8'd127}, 128, 0, '0);
        burst("R2 linear max", {1'b1, 4'h3, 8'd255}, 256, 0, '0);

        // R1 R3 R4: power-of-two sweep, with junk placed in the ratio field
        for (int e = 0; e < 16; e++) begin
            logic [12:0] w;
            w = {1'b0, 4'(e), 8'hA5};
            burst(e == 0 ? "R4 exponent zero" : "R3 power", w, exp_half(w), 0, w);
        end

        // R8: a mid-burst change is ignored until the next burst
        burst("R8 change held off", {1'b1, 4'h0, 8'd3}, 4, 2, {1'b1, 4'h0, 8'd0});
        burst("R8 change applied next burst", div_word, 1, 0, '0);

        // R9: fastest setting ticks every active cycle
        begin
            div_word    = {1'b1, 4'h0, 8'd0};
            xfer_active = 1'b1;
            for (int c = 1; c <= 6; c++) begin
                @(posedge clk);
                @(negedge clk);
                check("R9 tick every cycle", int'(sclk_tick), 1);
                check("R9 level alternates", int'(sclk_level), (c - 1) % 2);
            end
            idle_gap(3);
        end

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule